// File: doc/BRIEF.md
# Sequential Signed Booth Multiplier

This block multiplies two signed two's complement operands of `N` bits each (default 16) and returns their full `2N`-bit signed product. It works through the multiplier one bit at a time. In each cycle it looks at the current multiplier bit and the bit below it. The first bit is paired with a zero placed below the least significant position. From that pair the block adds the multiplicand into the upper half of its working register, subtracts it, or leaves the register alone. It then shifts the whole working register right by one place, keeping the sign. Signed operands therefore need no correction step at the end.

A client drives both operands and pulses `start` for one cycle while `busy` is low. The operands are captured on that clock edge. `busy` is then high for exactly `N` cycles. In the cycle after `busy` falls, `done` pulses for one cycle and `product` carries the result. The block applies no back-pressure to the result. `product` holds its value until the next accepted `start`, so a client that misses the `done` pulse can still read the result later. A `start` seen while `busy` is high is dropped. A `start` seen in the `done` cycle is accepted, which lets operations run back to back.

Top module: `booth_seq_mult`

## Requirements
- R1: After reset `busy` and `done` are 0 and `product` is 0.
- R2: A `start` pulse sampled while `busy` is 0 captures `mcand` and `mplr`, and `busy` is 1 from the next cycle on.
- R3: Once raised, `busy` stays high for exactly `N` consecutive cycles.
- R4: `done` is high for exactly one cycle, in the cycle right after `busy` falls, and `busy` and `done` are never high together.
- R5: When `done` is high, `product` equals the signed product of the two captured operands, reduced to `2N` bits.
- R6: The result is recoded from multiplier bit pairs (current bit, lower bit), with a zero below bit 0. Pair 01 adds the multiplicand, pair 10 subtracts it, and pairs 00 and 11 leave the accumulator unchanged. Mixed runs of ones and zeros (for example 0x5555, 0xAAAA, 0xFFFF) must still give the exact product.
- R7: The most negative value on either operand, or on both, gives the exact product (both most negative gives 2^(2N-2)), and the (N+1)-bit accumulator never overflows.
- R8: A `start` pulse sampled while `busy` is 1 is ignored: it neither changes the captured operands nor stretches or restarts the operation.
- R9: While no `start` is accepted, `product` keeps its value after `done`.
- R10: A `start` sampled in the `done` cycle is accepted and begins a new operation in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request that captures the operands when `busy` is low |
| mcand | input | N | Signed multiplicand |
| mplr | input | N | Signed multiplier |
| busy | output | 1 | High while the multiplier bits are being processed |
| done | output | 1 | One-cycle pulse that marks a valid product |
| product | output | 2N | Signed product, held until the next accepted start |

## Verification
The embedded assertions check the following on every cycle: `busy` and `done` stay exclusive, `done` is a single-cycle pulse that follows `busy`, the captured multiplicand stays fixed while `busy` is high, the result holds while idle, and the accumulator adder never overflows its sign. Arithmetic correctness can only be shown by the bench scenarios. These compare each product against an independently computed signed product across zero, unit, alternating-bit and extreme operands, and also count the `busy` length, drop a `start` issued mid-operation, and chain an operation directly off a `done` cycle.

// File: rtl/booth_pkg.sv
package booth_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } seq_state_e;

  typedef enum logic [1:0] {
    OP_SKIP = 2'd0,
    OP_ADD  = 2'd1,
    OP_SUB  = 2'd2
  } step_op_e;

endpackage

// File: rtl/booth_recoder.sv
module booth_recoder
  import booth_pkg::*;
(
  input  logic     cur_bit,
  input  logic     low_bit,
  output step_op_e op
);

  // R6: pair (cur, low): 01 add, 10 subtract, equal bits skip
  always_comb begin
    unique case ({cur_bit, low_bit})
      2'b01:   op = OP_ADD;
      2'b10:   op = OP_SUB;
      default: op = OP_SKIP;
    endcase
  end

endmodule

// File: rtl/booth_addsub.sv
module booth_addsub
  import booth_pkg::*;
#(
  parameter int W = 17
) (
  input  logic [W-1:0] acc,
  input  logic [W-1:0] addend,
  input  step_op_e     op,
  output logic [W-1:0] res
);

  logic [W-1:0] operand;
  logic         carry_in;

  always_comb begin
    operand  = '0;
    carry_in = 1'b0;
    case (op)
      OP_ADD: operand = addend;
      OP_SUB: begin
        operand  = ~addend;
        carry_in = 1'b1;
      end
      default: operand = '0;
    endcase
    res = acc + operand + W'(carry_in);
  end

endmodule

// File: rtl/booth_ctrl.sv
module booth_ctrl
  import booth_pkg::*;
#(
  parameter int N = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done,
  output logic load,
  output logic step
);

  localparam int CW = (N > 1) ? $clog2(N) : 1;
  localparam logic [CW-1:0] LAST = CW'(N - 1);

  seq_state_e      st;
  logic [CW-1:0]   cnt;
  logic            last;

  assign busy = (st == ST_RUN);
  assign done = (st == ST_DONE);
  assign step = busy;
  assign load = start && !busy;
  assign last = (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= ST_IDLE;
      cnt <= '0;
    end else begin
      case (st)
        ST_RUN: begin
          cnt <= cnt + 1'b1;
          if (last) st <= ST_DONE;
        end
        default: begin
          cnt <= '0;
          st  <= start ? ST_RUN : ST_IDLE;
        end
      endcase
    end
  end

  // R2
  load_to_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> busy);

  // R3
  run_continues_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last) |=> busy);

  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R4
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R4
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

endmodule

// File: rtl/booth_seq_mult.sv
module booth_seq_mult
  import booth_pkg::*;
#(
  parameter int N = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [N-1:0]   mcand,
  input  logic [N-1:0]   mplr,
  output logic           busy,
  output logic           done,
  output logic [2*N-1:0] product
);

  localparam int AW = N + 1;

  logic          load, step;
  logic [N-1:0]  mcand_q;
  logic [AW-1:0] acc_q;
  logic [N-1:0]  mq_q;
  logic          low_q;
  logic [AW-1:0] mcand_ext;
  logic [AW-1:0] sum;
  step_op_e      op;

  booth_ctrl #(.N(N)) u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .busy  (busy),
    .done  (done),
    .load  (load),
    .step  (step)
  );

  booth_recoder u_rec (
    .cur_bit (mq_q[0]),
    .low_bit (low_q),
    .op      (op)
  );

  assign mcand_ext = {mcand_q[N-1], mcand_q};

  booth_addsub #(.W(AW)) u_add (
    .acc    (acc_q),
    .addend (mcand_ext),
    .op     (op),
    .res    (sum)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcand_q <= '0;
      acc_q   <= '0;
      mq_q    <= '0;
      low_q   <= 1'b0;
    end else if (load) begin
      mcand_q <= mcand;
      acc_q   <= '0;
      mq_q    <= mplr;
      low_q   <= 1'b0;
    end else if (step) begin
      acc_q   <= {sum[AW-1], sum[AW-1:1]};
      mq_q    <= {sum[0], mq_q[N-1:1]};
      low_q   <= mq_q[0];
    end
  end

  assign product = {acc_q[N-1:0], mq_q};

  // R7
  no_overflow_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && op == OP_ADD && acc_q[AW-1] == mcand_ext[AW-1]) |-> (sum[AW-1] == acc_q[AW-1]));

  // R7
  no_overflow_sub_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && op == OP_SUB && acc_q[AW-1] != mcand_ext[AW-1]) |-> (sum[AW-1] == acc_q[AW-1]));

  // R8
  ignore_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(mcand_q));

  // R9
  product_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(product));

endmodule

// File: tb/booth_seq_mult_test.sv
module booth_seq_mult_test;

  localparam int N = 16;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start = 1'b0;
  logic [N-1:0]   mcand = '0;
  logic [N-1:0]   mplr = '0;
  logic           busy, done;
  logic [2*N-1:0] product;

  int n_cmp = 0;
  int n_bad = 0;
  logic [2*N-1:0] exp_q[$];
  logic [2*N-1:0] last_exp = '0;
  bit             have_last = 1'b0;
  int             busy_run = 0;
  int             cycles = 0;

  always #4 clk = ~clk;

  booth_seq_mult #(.N(N)) uut (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .mcand   (mcand),
    .mplr    (mplr),
    .busy    (busy),
    .done    (done),
    .product (product)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [2*N-1:0] ref_mul(input logic [N-1:0] a, input logic [N-1:0] b);
    logic [2*N-1:0] ea, eb;
    ea = {{N{a[N-1]}}, a};
    eb = {{N{b[N-1]}}, b};
    return ea * eb;
  endfunction

  // driver: waits for an accepting cycle, pushes the expected product, pulses start
  task automatic issue(input logic [N-1:0] a, input logic [N-1:0] b);
    @(negedge clk);
    while (busy) @(negedge clk);
    exp_q.push_back(ref_mul(a, b));
    mcand = a;
    mplr  = b;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // R8: start while busy must be dropped (nothing pushed)
  task automatic poke_busy(input logic [N-1:0] a, input logic [N-1:0] b);
    @(negedge clk);
    while (!busy) @(negedge clk);
    repeat (3) @(negedge clk);
    mcand = a;
    mplr  = b;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic drain;
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (busy) busy_run++;
      if (done) begin
        check(busy_run == N, "R3 busy length", 64'(busy_run), 64'(N));
        busy_run = 0;
        if (exp_q.size() == 0) begin
          check(1'b0, "R8 unexpected result", 64'(product), 64'd0);
        end else begin
          last_exp = exp_q.pop_front();
          check(product == last_exp, "R5/R6/R7 product", 64'(product), 64'(last_exp));
          have_last = 1'b1;
        end
      end else if (!busy && have_last) begin
        check(product == last_exp, "R9 product hold", 64'(product), 64'(last_exp));
      end
      check(!(busy && done), "R4 busy/done exclusive", {62'd0, busy, done}, 64'd0);
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(busy == 1'b0 && done == 1'b0 && product == '0, "R1 reset state",
          {31'd0, busy, done, product}, 64'd0);
    rst_n = 1'b1;

    // R2: busy rises the cycle after start
    @(negedge clk);
    exp_q.push_back(ref_mul(16'd3, 16'd7));
    mcand = 16'd3; mplr = 16'd7; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R2 busy after start", 64'(busy), 64'd1);
    drain();

    // R5 basic patterns
    issue(16'd0, 16'h1234);
    issue(16'd1, 16'd1);
    issue(16'hFFFF, 16'hFFFF);
    issue(16'h7FFF, 16'h7FFF);
    // R6 mixed runs of ones and zeros
    issue(16'h5555, 16'hAAAA);
    issue(16'h1234, 16'h5555);
    issue(16'hABCD, 16'hFFFF);
    issue(16'h00F0, 16'h0F0F);
    // R7 most negative operands
    issue(16'h8000, 16'h8000);
    issue(16'h8000, 16'h7FFF);
    issue(16'h7FFF, 16'h8000);
    issue(16'h8000, 16'h0001);
    issue(16'hFFFF, 16'h8000);
    drain();

    // R9: hold several idle cycles
    repeat (5) @(negedge clk);

    // R8: start mid-operation ignored
    issue(16'h0123, 16'h0456);
    poke_busy(16'h7777, 16'h8888);
    drain();

    // R10: back-to-back, start in done cycle
    issue(16'hF00D, 16'h0BAD);
    @(negedge clk);
    while (!done) @(negedge clk);
    exp_q.push_back(ref_mul(16'h4321, 16'hC001));
    mcand = 16'h4321; mplr = 16'hC001; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R10 start in done cycle accepted", 64'(busy), 64'd1);
    drain();

    // random mix
    for (int i = 0; i < 30; i++) begin
      issue(N'($urandom), N'($urandom));
    end
    drain();
    repeat (3) @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule